// File: doc/BRIEF.md
# DDR Bank Command Timer

This block sits between a DDR SDRAM controller's scheduler and the command pins of a four-bank device. For the command currently presented it tells the scheduler, in the same cycle, whether an activate, a read, a write or a precharge would respect every minimum spacing rule. When a command is strobed it is issued only if it is legal. An illegal command is dropped and reported on a one-cycle violation pulse, and it changes no state.

The block keeps, for every bank, whether it is open and which row it holds. All spacing rules are counted in clock cycles. Each cycle count is derived at elaboration by rounding a picosecond value up to whole cycles of the clock period parameter. The rules cover activate to column command, activate to precharge, precharge to activate, activate to activate on the same bank and across banks, write recovery, write to read turnaround and the auto-precharge recovery term. A bank left open longer than the row-active maximum also raises the violation pulse, once.

Top module: `ddr_bank_timer`

## Requirements
- R1: While and after reset every bank is closed, no violation is flagged and every spacing rule counts as met. For a closed bank this gives actOk=1, rdOk=0, wrOk=0 and preOk=1.
- R2: An issued ACTIVATE (code 2'b00) opens the bank on cmdBank and stores the 13-bit cmdAddr as its row. An ACTIVATE to a bank that is already open is illegal.
- R3: A READ (code 2'b01) or WRITE (code 2'b10) needs its bank open and at least tRCD = 3 edges since that bank's ACTIVATE. A column command to a closed bank is illegal.
- R4: A PRECHARGE (code 2'b11) of an open bank needs three spacings on that bank, each counted from the named command: tRAS min = 6 edges since ACTIVATE, 2 edges since a READ, and burst plus tWR = 4 edges since a WRITE.
- R5: An ACTIVATE to a bank needs 3 edges (tRP) since that bank was precharged and 9 edges (tRC) since its previous ACTIVATE.
- R6: Any two ACTIVATE commands, to any banks, are at least tRRD = 2 edges apart.
- R7: A READ to any bank needs at least burst plus tWTR = 3 edges since the last WRITE to any bank. A WRITE has no such limit.
- R8: A READ or WRITE with address bit 10 set closes its bank at that edge. The next ACTIVATE to that bank then also needs the bank's R4 precharge point plus tRP, which after a write is burst + ceil(tWR) + ceil(tRP) = 2 + 5 = 7 edges.
- R9: A PRECHARGE with address bit 10 set closes every open bank and is legal only if all open banks meet R4. With bit 10 clear it acts on cmdBank alone. A PRECHARGE of a closed bank is legal and changes nothing.
- R10: actOk, rdOk, wrOk and preOk are combinational judgements for the presented cmdBank and bit 10. A strobed command whose flag is low is dropped, leaves all bank state untouched, and makes violation high for exactly the next cycle.
- R11: A bank still open 16000 edges after its ACTIVATE (tRAS max) makes violation high for one cycle, once per opening, unless it is closed at that edge.
- R12: Every spacing is ceil(ps / CLK_PS) with CLK_PS = 7500: 20000 ps gives 3, 45000 gives 6, 65000 gives 9, 15000 gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Strobe: issue the presented command at this edge |
| cmdCode | input | 2 | 00 activate, 01 read, 10 write, 11 precharge |
| cmdBank | input | 2 | Target bank |
| cmdAddr | input | 13 | Row on activate; bit 10 selects auto-precharge or precharge-all |
| actOk | output | 1 | Activate to cmdBank would be legal now |
| rdOk | output | 1 | Read to cmdBank would be legal now |
| wrOk | output | 1 | Write to cmdBank would be legal now |
| preOk | output | 1 | Precharge (per bit 10) would be legal now |
| bankOpen | output | 4 | Per-bank open flag |
| bankRow | output | 52 | Per-bank stored row, bank i at bits [13i+12:13i] |
| violation | output | 1 | One-cycle pulse after a dropped command or a row-active overrun |

## Verification
A directed prologue fires each command at the edge just before and at the edge its spacing is met. This separates an off-by-one in any timer from a wrong load value, and it shows whether the write-to-read, cross-bank activate and auto-precharge terms are applied to the right bank. A long pseudo-random stream of mixed commands and banks, about half of them illegal, exercises interaction between timers and the rule that dropped commands leave state alone. A final quiet stretch with one bank left open, after a precharge-all, checks the single overrun pulse and its exact cycle. A behavioural reference built on absolute edge numbers is compared with every output on every cycle.

// File: rtl/ddr_bank_timer_pkg.sv
package ddr_bank_timer_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_PRE = 2'b11
  } cmdCode_e;

  // strobes from control to datapath, one edge each
  typedef struct packed {
    logic doAct;
    logic doRd;
    logic doWr;
    logic doPre;
    logic apFlag;   // address bit 10 of the presented command
    logic illegal;
  } cmdStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_bank_ctrl.sv
module ddr_bank_ctrl
  import ddr_bank_timer_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int BANK_W = 2
) (
  input  logic              cmdValid,
  input  logic [1:0]        cmdCode,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              apBit,
  input  logic [BANKS-1:0]  bankOpen,
  input  logic [BANKS-1:0]  rwRdy,
  input  logic [BANKS-1:0]  preRdy,
  input  logic [BANKS-1:0]  actRdy,
  input  logic              rrdRdy,
  input  logic              wtrRdy,
  output logic              actOk,
  output logic              rdOk,
  output logic              wrOk,
  output logic              preOk,
  output cmdStrobe_t        strobe
);

  cmdCode_e code;
  logic     selOpen;
  logic     granted;

  assign code = cmdCode_e'(cmdCode);

  always_comb begin
    selOpen = bankOpen[cmdBank];
    actOk   = !selOpen && actRdy[cmdBank] && rrdRdy;
    rdOk    = selOpen && rwRdy[cmdBank] && wtrRdy;
    wrOk    = selOpen && rwRdy[cmdBank];
    preOk   = apBit ? (&(~bankOpen | preRdy))
                    : (!selOpen || preRdy[cmdBank]);
    unique case (code)
      CMD_ACT: granted = actOk;
      CMD_RD:  granted = rdOk;
      CMD_WR:  granted = wrOk;
      default: granted = preOk;
    endcase
  end

  always_comb begin
    strobe.doAct   = cmdValid && (code == CMD_ACT) && actOk;
    strobe.doRd    = cmdValid && (code == CMD_RD)  && rdOk;
    strobe.doWr    = cmdValid && (code == CMD_WR)  && wrOk;
    strobe.doPre   = cmdValid && (code == CMD_PRE) && preOk;
    strobe.apFlag  = apBit;
    strobe.illegal = cmdValid && !granted;
  end

endmodule

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot #(
  parameter int ROW_W    = 13,
  parameter int TW       = 4,
  parameter int AW       = 14,
  parameter int C_RCD    = 3,
  parameter int C_RAS    = 6,
  parameter int C_RASMAX = 16000,
  parameter int C_RP     = 3,
  parameter int C_RC     = 9,
  parameter int C_BURST  = 2,
  parameter int C_WR     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             doAct,
  input  logic             doRd,
  input  logic             doWr,
  input  logic             doPre,
  input  logic             autoPre,
  input  logic [ROW_W-1:0] rowIn,
  output logic             isOpen,
  output logic [ROW_W-1:0] openRow,
  output logic             rwRdy,
  output logic             preRdy,
  output logic             actRdy,
  output logic             overdue
);

  localparam logic [TW-1:0] L_RCD   = TW'(C_RCD - 1);
  localparam logic [TW-1:0] L_RAS   = TW'(C_RAS - 1);
  localparam logic [TW-1:0] L_RDPRE = TW'(C_BURST - 1);
  localparam logic [TW-1:0] L_WRPRE = TW'(C_BURST + C_WR - 1);
  localparam logic [TW-1:0] L_RC    = TW'(C_RC - 1);
  localparam logic [TW-1:0] L_RP    = TW'(C_RP - 1);
  localparam logic [TW-1:0] ADD_RP  = TW'(C_RP);
  localparam logic [AW-1:0] AGE_LIM = AW'(C_RASMAX);
  localparam logic [AW-1:0] AGE_HIT = AW'(C_RASMAX - 1);

  logic [TW-1:0] rcdWait, preWait, actWait;
  logic [TW-1:0] rcdNext, preNext, actNext;
  logic [AW-1:0] age;
  logic          closeAp, closePre, closing;

  function automatic logic [TW-1:0] tick(input logic [TW-1:0] w);
    return (w == '0) ? '0 : w - TW'(1);
  endfunction

  function automatic logic [TW-1:0] maxT(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign closeAp  = (doRd || doWr) && autoPre;
  assign closePre = doPre && isOpen;
  assign closing  = closeAp || closePre;

  always_comb begin
    rcdNext = doAct ? L_RCD : tick(rcdWait);

    preNext = tick(preWait);
    if (doAct) preNext = maxT(preNext, L_RAS);
    if (doRd)  preNext = maxT(preNext, L_RDPRE);
    if (doWr)  preNext = maxT(preNext, L_WRPRE);

    actNext = tick(actWait);
    if (doAct)    actNext = maxT(actNext, L_RC);
    if (closeAp)  actNext = maxT(actNext, preNext + ADD_RP);
    if (closePre) actNext = maxT(actNext, L_RP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isOpen  <= 1'b0;
      openRow <= '0;
      rcdWait <= '0;
      preWait <= '0;
      actWait <= '0;
      age     <= '0;
    end else begin
      rcdWait <= rcdNext;
      preWait <= preNext;
      actWait <= actNext;
      if (doAct) begin
        isOpen  <= 1'b1;
        openRow <= rowIn;
        age     <= '0;
      end else if (closing) begin
        isOpen  <= 1'b0;
      end else if (isOpen && (age != AGE_LIM)) begin
        age     <= age + AW'(1);
      end
    end
  end

  assign rwRdy   = (rcdWait == '0);
  assign preRdy  = (preWait == '0);
  assign actRdy  = (actWait == '0);
  assign overdue = isOpen && !closing && (age == AGE_HIT);

  // R2
  act_on_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    doAct |-> (!isOpen && actWait == '0));

  // R2
  act_opens_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    doAct |=> (isOpen && openRow == $past(rowIn)));

  // R3
  col_after_rcd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doRd || doWr) |-> (isOpen && rcdWait == '0));

  // R4
  pre_after_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doPre && isOpen) |-> (preWait == '0));

  // R11
  overdue_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    overdue |=> !overdue);

endmodule

// File: rtl/ddr_bank_dp.sv
module ddr_bank_dp
  import ddr_bank_timer_pkg::*;
#(
  parameter int BANKS    = 4,
  parameter int BANK_W   = 2,
  parameter int ROW_W    = 13,
  parameter int TW       = 4,
  parameter int AW       = 14,
  parameter int C_RCD    = 3,
  parameter int C_RAS    = 6,
  parameter int C_RASMAX = 16000,
  parameter int C_RP     = 3,
  parameter int C_RC     = 9,
  parameter int C_RRD    = 2,
  parameter int C_BURST  = 2,
  parameter int C_WR     = 2,
  parameter int C_WTR    = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cmdStrobe_t             strobe,
  input  logic [BANK_W-1:0]      cmdBank,
  input  logic [ROW_W-1:0]       cmdAddr,
  output logic [BANKS-1:0]       bankOpen,
  output logic [BANKS*ROW_W-1:0] bankRow,
  output logic [BANKS-1:0]       rwRdy,
  output logic [BANKS-1:0]       preRdy,
  output logic [BANKS-1:0]       actRdy,
  output logic                   rrdRdy,
  output logic                   wtrRdy,
  output logic                   violation
);

  localparam logic [TW-1:0] L_RRD = TW'(C_RRD - 1);
  localparam logic [TW-1:0] L_WTR = TW'(C_BURST + C_WTR - 1);

  logic [BANKS-1:0] overdueVec;
  logic [TW-1:0]    rrdWait, wtrWait;

  for (genvar g = 0; g < BANKS; g++) begin : gBank
    logic bankHit;
    assign bankHit = (cmdBank == BANK_W'(g));

    ddr_bank_slot #(
      .ROW_W(ROW_W), .TW(TW), .AW(AW),
      .C_RCD(C_RCD), .C_RAS(C_RAS), .C_RASMAX(C_RASMAX),
      .C_RP(C_RP), .C_RC(C_RC), .C_BURST(C_BURST), .C_WR(C_WR)
    ) uSlot (
      .clk    (clk),
      .rstN   (rstN),
      .doAct  (strobe.doAct && bankHit),
      .doRd   (strobe.doRd && bankHit),
      .doWr   (strobe.doWr && bankHit),
      .doPre  (strobe.doPre && (strobe.apFlag || bankHit)),
      .autoPre(strobe.apFlag),
      .rowIn  (cmdAddr),
      .isOpen (bankOpen[g]),
      .openRow(bankRow[g*ROW_W +: ROW_W]),
      .rwRdy  (rwRdy[g]),
      .preRdy (preRdy[g]),
      .actRdy (actRdy[g]),
      .overdue(overdueVec[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrdWait   <= '0;
      wtrWait   <= '0;
      violation <= 1'b0;
    end else begin
      if (strobe.doAct)          rrdWait <= L_RRD;
      else if (rrdWait != '0)    rrdWait <= rrdWait - TW'(1);
      if (strobe.doWr)           wtrWait <= L_WTR;
      else if (wtrWait != '0)    wtrWait <= wtrWait - TW'(1);
      violation <= strobe.illegal || (|overdueVec);
    end
  end

  assign rrdRdy = (rrdWait == '0);
  assign wtrRdy = (wtrWait == '0);

  // R6
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAct |-> (rrdWait == '0));

  // R7
  read_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRd |-> (wtrWait == '0));

  // R10
  dropped_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.illegal && !(|overdueVec)) |=> $stable(bankOpen));

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer
  import ddr_bank_timer_pkg::*;
#(
  parameter int CLK_PS      = 7500,
  parameter int TRCD_PS     = 20000,
  parameter int TRAS_PS     = 45000,
  parameter int TRAS_MAX_PS = 120000000,
  parameter int TRP_PS      = 20000,
  parameter int TRC_PS      = 65000,
  parameter int TRRD_PS     = 15000,
  parameter int TWR_PS      = 15000,
  parameter int TWTR_CYC    = 1,
  parameter int BURST_LEN   = 4,
  parameter int BANKS       = 4,
  parameter int ROW_W       = 13,
  parameter int AP_BIT      = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmdValid,
  input  logic [1:0]               cmdCode,
  input  logic [$clog2(BANKS)-1:0] cmdBank,
  input  logic [ROW_W-1:0]         cmdAddr,
  output logic                     actOk,
  output logic                     rdOk,
  output logic                     wrOk,
  output logic                     preOk,
  output logic [BANKS-1:0]         bankOpen,
  output logic [BANKS*ROW_W-1:0]   bankRow,
  output logic                     violation
);

  localparam int BANK_W  = $clog2(BANKS);
  localparam int cRcd    = ceilDiv(TRCD_PS, CLK_PS);
  localparam int cRas    = ceilDiv(TRAS_PS, CLK_PS);
  localparam int cRasMax = ceilDiv(TRAS_MAX_PS, CLK_PS);
  localparam int cRp     = ceilDiv(TRP_PS, CLK_PS);
  localparam int cRc     = ceilDiv(TRC_PS, CLK_PS);
  localparam int cRrd    = ceilDiv(TRRD_PS, CLK_PS);
  localparam int cWr     = ceilDiv(TWR_PS, CLK_PS);
  localparam int cBurst  = BURST_LEN / 2;
  localparam int LONGEST = maxOf(maxOf(cRc, cBurst + cWr + cRp),
                                 maxOf(maxOf(cRas + cRp, cRcd),
                                       maxOf(cRrd, cBurst + TWTR_CYC)));
  localparam int TW      = $clog2(LONGEST + 1);
  localparam int AW      = $clog2(cRasMax + 1);

  cmdStrobe_t       strobe;
  logic [BANKS-1:0] rwRdy, preRdy, actRdy;
  logic             rrdRdy, wtrRdy;

  ddr_bank_ctrl #(.BANKS(BANKS), .BANK_W(BANK_W)) uCtrl (
    .cmdValid(cmdValid),
    .cmdCode (cmdCode),
    .cmdBank (cmdBank),
    .apBit   (cmdAddr[AP_BIT]),
    .bankOpen(bankOpen),
    .rwRdy   (rwRdy),
    .preRdy  (preRdy),
    .actRdy  (actRdy),
    .rrdRdy  (rrdRdy),
    .wtrRdy  (wtrRdy),
    .actOk   (actOk),
    .rdOk    (rdOk),
    .wrOk    (wrOk),
    .preOk   (preOk),
    .strobe  (strobe)
  );

  ddr_bank_dp #(
    .BANKS(BANKS), .BANK_W(BANK_W), .ROW_W(ROW_W), .TW(TW), .AW(AW),
    .C_RCD(cRcd), .C_RAS(cRas), .C_RASMAX(cRasMax), .C_RP(cRp),
    .C_RC(cRc), .C_RRD(cRrd), .C_BURST(cBurst), .C_WR(cWr),
    .C_WTR(TWTR_CYC)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdBank  (cmdBank),
    .cmdAddr  (cmdAddr),
    .bankOpen (bankOpen),
    .bankRow  (bankRow),
    .rwRdy    (rwRdy),
    .preRdy   (preRdy),
    .actRdy   (actRdy),
    .rrdRdy   (rrdRdy),
    .wtrRdy   (wtrRdy),
    .violation(violation)
  );

endmodule

// File: tb/ddr_bank_timer_test.sv
`timescale 1ns/1ps
module ddr_bank_timer_test;

  localparam int T_RCD = 3, T_RAS = 6, T_RASMAX = 16000, T_RP = 3, T_RC = 9;
  localparam int T_RRD = 2, T_WR = 2, T_BURST = 2, T_WTR = 1;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid;
  logic [1:0]  cmdCode;
  logic [1:0]  cmdBank;
  logic [12:0] cmdAddr;
  logic        actOk, rdOk, wrOk, preOk, violation;
  logic [3:0]  bankOpen;
  logic [51:0] bankRow;

  always #4 clk = ~clk;

  ddr_bank_timer uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdBank(cmdBank), .cmdAddr(cmdAddr), .actOk(actOk), .rdOk(rdOk),
    .wrOk(wrOk), .preOk(preOk), .bankOpen(bankOpen), .bankRow(bankRow),
    .violation(violation)
  );

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit mOpen[4];
  int mRow[4], actR[4], preR[4], rwR[4], ageStart[4];
  int rrdR = 0, wtrR = 0;
  bit mViol = 1'b0;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit expAct(int b);
    return !mOpen[b] && n >= actR[b] && n >= rrdR;
  endfunction
  function automatic bit expRd(int b);
    return mOpen[b] && n >= rwR[b] && n >= wtrR;
  endfunction
  function automatic bit expWr(int b);
    return mOpen[b] && n >= rwR[b];
  endfunction
  function automatic bit expPre(int b, bit ap);
    bit ok = 1'b1;
    if (ap) begin
      for (int i = 0; i < 4; i++) if (mOpen[i] && n < preR[i]) ok = 1'b0;
    end else begin
      ok = !mOpen[b] || n >= preR[b];
    end
    return ok;
  endfunction

  task automatic checkVal(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", tag, what, act, exp, n);
    end
  endtask

  task automatic modelEdge(bit v, int code, int b, int addr);
    bit ap = addr[10];
    bit ok;
    bit wasOpen[4];
    bit closeB[4];
    bit ov = 1'b0;
    for (int i = 0; i < 4; i++) begin wasOpen[i] = mOpen[i]; closeB[i] = 1'b0; end
    case (code)
      0: ok = expAct(b);
      1: ok = expRd(b);
      2: ok = expWr(b);
      default: ok = expPre(b, ap);
    endcase
    if (v && ok) begin
      case (code)
        0: begin
          mOpen[b] = 1'b1; mRow[b] = addr; rwR[b] = n + T_RCD;
          preR[b] = n + T_RAS; actR[b] = imax(actR[b], n + T_RC);
          rrdR = n + T_RRD; ageStart[b] = n;
        end
        1, 2: begin
          if (code == 1) preR[b] = imax(preR[b], n + T_BURST);
          else begin
            preR[b] = imax(preR[b], n + T_BURST + T_WR);
            wtrR = n + T_BURST + T_WTR;
          end
          if (ap) begin
            closeB[b] = 1'b1; mOpen[b] = 1'b0;
            actR[b] = imax(actR[b], preR[b] + T_RP);
          end
        end
        default: begin
          for (int i = 0; i < 4; i++) begin
            if ((ap || i == b) && mOpen[i]) begin
              closeB[i] = 1'b1; mOpen[i] = 1'b0;
              actR[i] = imax(actR[i], n + T_RP);
            end
          end
        end
      endcase
    end
    for (int i = 0; i < 4; i++)
      if (wasOpen[i] && !closeB[i] && (n - ageStart[i] == T_RASMAX)) ov = 1'b1;
    mViol = (v && !ok) || ov;
  endtask

  // drive at the falling edge, compare 1 ns later, model the rising edge
  task automatic step(bit v, int code, int b, int addr);
    cmdValid = v; cmdCode = code[1:0]; cmdBank = b[1:0]; cmdAddr = addr[12:0];
    #1;
    // R12: expected spacings use the rounded cycle counts 3/6/9/2
    checkVal("R2 R5 R6 R8 R12", "actOk", actOk, expAct(b));
    checkVal("R3 R7 R12", "rdOk", rdOk, expRd(b));
    checkVal("R3", "wrOk", wrOk, expWr(b));
    checkVal("R4 R9", "preOk", preOk, expPre(b, addr[10]));
    for (int i = 0; i < 4; i++) begin
      checkVal("R2 R8 R9", "bankOpen", bankOpen[i], mOpen[i]);
      checkVal("R2", "bankRow", bankRow[i*13 +: 13], mRow[i]);
    end
    checkVal("R10 R11", "violation", violation, mViol);
    @(posedge clk);
    modelEdge(v, code, b, addr);
    n++;
    @(negedge clk);
  endtask

  initial begin
    #(8.0 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      mOpen[i] = 0; mRow[i] = 0; actR[i] = 0; preR[i] = 0; rwR[i] = 0; ageStart[i] = 0;
    end
    rstN = 1'b0; cmdValid = 1'b0; cmdCode = 2'b00; cmdBank = 2'b00; cmdAddr = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    checkVal("R1", "bankOpen", bankOpen, 0);
    checkVal("R1", "violation", violation, 0);
    checkVal("R1", "actOk", actOk, 1);
    checkVal("R1", "rdOk", rdOk, 0);
    checkVal("R1", "wrOk", wrOk, 0);
    checkVal("R1", "preOk", preOk, 1);
    @(negedge clk);
    rstN = 1'b1;

    // directed: boundary edges of each spacing
    step(1, 0, 0, 'h1234);          // ACT b0
    step(1, 1, 0, 0);               // RD too early (R3)
    step(1, 0, 1, 'h0777);          // ACT b1 at tRRD
    step(1, 1, 0, 0);               // RD b0 at tRCD
    step(1, 2, 1, 0);               // WR b1 too early
    step(1, 2, 1, 0);               // WR b1 legal
    step(1, 1, 0, 0);               // RD blocked by write turnaround (R7)
    step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    step(1, 3, 1, 0);               // PRE b1 after write recovery (R4)
    for (int k = 0; k < 4; k++) step(1, 0, 1, 'h0abc);   // ACT b1 vs tRP/tRC (R5)
    step(1, 0, 0, 'h0001);          // ACT to open bank (R2)
    step(1, 2, 0, 'h400);           // WR b0 with auto-precharge (R8)
    step(1, 1, 0, 0);               // RD to now-closed bank
    for (int k = 0; k < 9; k++) step(1, 0, 0, 'h1555);   // ACT b0 vs auto-precharge recovery
    step(1, 3, 3, 0);               // PRE of closed bank (R9)
    for (int k = 0; k < 8; k++) step(1, 3, 2, 'h400);    // PRE all (R9)
    step(0, 0, 0, 0);

    // mixed pseudo-random stream
    for (int k = 0; k < 4000; k++)
      step(($urandom % 10) < 6, $urandom % 4, $urandom % 4, $urandom % 8192);

    // row-active maximum (R11)
    for (int k = 0; k < 12; k++) step(0, 0, 0, 0);
    for (int k = 0; k < 6; k++) step(1, 3, 0, 'h400);
    step(1, 0, 2, 'h0f0f);
    for (int k = 0; k < T_RASMAX + 6; k++) step(0, 1, 2, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule